// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short queue of 8-bit completion records for a frame transmitter. Each time the transmitter finishes a frame, it presents one push with four condition flags: interrupt requested on success, jabber, underrun and maximum collisions. The block turns that push into a record and stores it. The host sees the oldest stored record on a read port at all times. A one-cycle write strobe from the host discards that record, and the next one becomes visible.

When a push finds the queue full and the host is not removing a record in the same cycle, the new record is dropped. The overflow bit is then set in the newest record already stored, so the host learns that at least one completion was lost. A jabber or underrun is fatal to the transmitter. It raises a sticky "needs reset" output that stays high until the transmitter reset input is applied. That reset empties the queue and clears every flag. A push that asks for an interrupt or reports any error also produces a one-cycle completion interrupt pulse.

The push side carries data flowing in, but it has no back-pressure. The transmitter cannot stall once a frame is on the wire, so `push_valid` alone qualifies a push and every push is taken, either stored or counted as an overflow. The host read side is a plain register view: `rd_data` is always valid and `host_pop` is a strobe.

Top module: `txs_stack`

## Requirements
- R1: A stored record reads as: bit 7 = 1 (complete), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow (0 when pushed), and bits 1..0 = 0. A push into an empty queue appears on `rd_data` one cycle after the push edge.
- R2: Records are presented oldest first, in push order.
- R3: `host_pop` high for one cycle removes the record on `rd_data`. The next record, or 0 if none is left, appears one cycle later.
- R4: An empty queue reads as 8'h00. A pop while the queue is empty has no effect.
- R5: A push while the queue holds DEPTH records, with no pop in the same cycle, is dropped. Bit 2 is set in the newest stored record, and the order and the other bits of the stored records are unchanged.
- R6: A push and a pop in the same cycle on a full queue removes the oldest record and stores the new one.
- R7: `needs_reset` rises one cycle after a push with jabber or underrun set, whether that record is stored or dropped. It then stays high until `tx_rst`.
- R8: `tx_rst` empties the queue and clears `needs_reset` and `cmpl_irq` on the next edge. It takes priority over a push or pop in the same cycle.
- R9: `cmpl_irq` is high for exactly the one cycle after a push that has the interrupt-request, jabber, underrun or maximum-collisions flag set, whether the record is stored or dropped. At all other times it is low.
- R10: While `rst_n` is low, `rd_data`, `needs_reset` and `cmpl_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_rst | input | 1 | Transmitter reset: clears queue and flags |
| push_valid | input | 1 | One completion this cycle (never back-pressured) |
| push_int_req | input | 1 | Interrupt on success requested |
| push_jabber | input | 1 | Jabber error |
| push_underrun | input | 1 | Underrun error |
| push_max_coll | input | 1 | Maximum collisions reached |
| host_pop | input | 1 | Host write strobe: discard the oldest record |
| rd_data | output | 8 | Oldest record, or 0 when empty |
| needs_reset | output | 1 | Sticky: transmitter reset required |
| cmpl_irq | output | 1 | One-cycle completion interrupt |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. This holds for a new head on `rd_data` after a push or pop, the overflow mark, the rise or clear of `needs_reset`, and the `cmpl_irq` pulse. The bench drives each input set on the falling edge and updates its queue model for the following rising edge. It then compares all three outputs 1 ns after that edge, before the next inputs change. This way each check lands on the single cycle in which the requirement places the result, and a result that arrives a cycle early or late is reported.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef struct packed {
    logic       done;
    logic       irq_req;
    logic       jabber;
    logic       underrun;
    logic       max_coll;
    logic       ovf;
    logic [1:0] rsvd;
  } txs_rec_t;

  function automatic txs_rec_t txs_make(input logic ir, input logic jb,
                                        input logic un, input logic mc);
    txs_rec_t r;
    r.done     = 1'b1;
    r.irq_req  = ir;
    r.jabber   = jb;
    r.underrun = un;
    r.max_coll = mc;
    r.ovf      = 1'b0;
    r.rsvd     = 2'b00;
    return r;
  endfunction

  function automatic logic txs_fatal(input txs_rec_t r);
    return r.jabber | r.underrun;
  endfunction

  function automatic logic txs_wants_irq(input txs_rec_t r);
    return r.irq_req | r.jabber | r.underrun | r.max_coll;
  endfunction

endpackage

// File: rtl/txs_encode.sv
module txs_encode
  import txs_pkg::*;
(
  input  logic     push_int_req,
  input  logic     push_jabber,
  input  logic     push_underrun,
  input  logic     push_max_coll,
  output txs_rec_t rec
);
  always_comb rec = txs_make(push_int_req, push_jabber, push_underrun, push_max_coll);
endmodule

// File: rtl/txs_store.sv
module txs_store
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     push,
  input  txs_rec_t wr_rec,
  input  logic     pop,
  output txs_rec_t head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] rd_ptr, wr_ptr, last_ptr;
  logic [CNT_W-1:0] count;
  txs_rec_t         mem [DEPTH];
  logic             empty, full, pop_ok, push_ok, mark_ovf;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    empty    = (count == '0);
    full     = (count == CNT_W'(DEPTH));
    pop_ok   = pop && !empty;
    push_ok  = push && (!full || pop_ok);
    mark_ovf = push && full && !pop_ok;
    last_ptr = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - PTR_W'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem[i] <= '0;
      else if (clr)                                mem[i] <= '0;
      else if (push_ok && wr_ptr == PTR_W'(i))     mem[i] <= wr_rec;
      else if (mark_ovf && last_ptr == PTR_W'(i))  mem[i].ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
      else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
    end
  end

  always_comb head = empty ? '0 : mem[rd_ptr];
endmodule

// File: rtl/txs_flags.sv
module txs_flags
  import txs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     push,
  input  txs_rec_t rec,
  output logic     needs_reset,
  output logic     irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      needs_reset <= 1'b0;
      irq         <= 1'b0;
    end else if (clr) begin
      needs_reset <= 1'b0;
      irq         <= 1'b0;
    end else begin
      if (push && txs_fatal(rec)) needs_reset <= 1'b1;
      irq <= push && txs_wants_irq(rec);
    end
  end
endmodule

// File: rtl/txs_stack.sv
module txs_stack
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_rst,
  input  logic       push_valid,
  input  logic       push_int_req,
  input  logic       push_jabber,
  input  logic       push_underrun,
  input  logic       push_max_coll,
  input  logic       host_pop,
  output logic [7:0] rd_data,
  output logic       needs_reset,
  output logic       cmpl_irq
);
  txs_rec_t new_rec, head;

  txs_encode u_enc (
    .push_int_req (push_int_req),
    .push_jabber  (push_jabber),
    .push_underrun(push_underrun),
    .push_max_coll(push_max_coll),
    .rec          (new_rec)
  );

  txs_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tx_rst),
    .push  (push_valid),
    .wr_rec(new_rec),
    .pop   (host_pop),
    .head  (head)
  );

  txs_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (tx_rst),
    .push       (push_valid),
    .rec        (new_rec),
    .needs_reset(needs_reset),
    .irq        (cmpl_irq)
  );

  assign rd_data = head;
endmodule

// File: rtl/txs_stack_chk.sv
module txs_stack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_rst,
  input logic       push_valid,
  input logic       push_int_req,
  input logic       push_jabber,
  input logic       push_underrun,
  input logic       push_max_coll,
  input logic       host_pop,
  input logic [7:0] rd_data,
  input logic       needs_reset,
  input logic       cmpl_irq
);
  logic wants_irq;
  assign wants_irq = push_valid && (push_int_req || push_jabber || push_underrun || push_max_coll);

  a_r1_format: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data != 8'h00) |-> (rd_data[7] && rd_data[1:0] == 2'b00));

  a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == 8'h00 && !push_valid) |=> (rd_data == 8'h00));

  a_r7_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && (push_jabber || push_underrun) && !tx_rst) |=> needs_reset);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (needs_reset && !tx_rst) |=> needs_reset);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> (rd_data == 8'h00 && !needs_reset && !cmpl_irq));

  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wants_irq && !tx_rst) |=> cmpl_irq);

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wants_irq) |=> !cmpl_irq);
endmodule

bind txs_stack txs_stack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .push_valid(push_valid),
  .push_int_req(push_int_req), .push_jabber(push_jabber),
  .push_underrun(push_underrun), .push_max_coll(push_max_coll),
  .host_pop(host_pop), .rd_data(rd_data), .needs_reset(needs_reset),
  .cmpl_irq(cmpl_irq)
);

// File: tb/txs_stack_tb_top.sv
`timescale 1ns/100ps
module txs_stack_tb_top;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_rst = 1'b0, push_valid = 1'b0, push_int_req = 1'b0, push_jabber = 1'b0;
  logic push_underrun = 1'b0, push_max_coll = 1'b0, host_pop = 1'b0;
  logic [7:0] rd_data;
  logic needs_reset, cmpl_irq;

  always #2.5 clk = ~clk;

  txs_stack #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .push_valid(push_valid),
    .push_int_req(push_int_req), .push_jabber(push_jabber),
    .push_underrun(push_underrun), .push_max_coll(push_max_coll),
    .host_pop(host_pop), .rd_data(rd_data), .needs_reset(needs_reset),
    .cmpl_irq(cmpl_irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] q[$];
  bit m_nr = 1'b0;
  bit m_irq = 1'b0;

  function automatic logic [7:0] m_head();
    return (q.size() > 0) ? q[0] : 8'h00;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit p, bit ir, bit jb, bit un, bit mc, bit pop, bit rst, string tag);
    @(negedge clk);
    push_valid = p; push_int_req = ir; push_jabber = jb; push_underrun = un;
    push_max_coll = mc; host_pop = pop; tx_rst = rst;
    m_irq = 1'b0;
    if (rst) begin
      q.delete();
      m_nr = 1'b0;
    end else begin
      if (pop && q.size() > 0) void'(q.pop_front());
      if (p) begin
        m_irq = ir | jb | un | mc;
        if (jb | un) m_nr = 1'b1;
        if (q.size() < DEPTH) q.push_back({1'b1, ir, jb, un, mc, 3'b000});
        else q[q.size()-1][2] = 1'b1;
      end
    end
    @(posedge clk);
    #1;
    check(tag, "rd_data", int'(rd_data), int'(m_head()));
    check((rst ? "R8" : "R7"), "needs_reset", int'(needs_reset), int'(m_nr));
    check((rst ? "R8" : "R9"), "cmpl_irq", int'(cmpl_irq), int'(m_irq));
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R10: outputs held at zero in reset
    repeat (3) @(posedge clk);
    #1;
    check("R10", "rd_data", int'(rd_data), 0);
    check("R10", "needs_reset", int'(needs_reset), 0);
    check("R10", "cmpl_irq", int'(cmpl_irq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: pop on empty ignored, reads zero
    step(0, 0, 0, 0, 0, 1, 0, "R4");
    idle("R4");
    // R1: single record format, R9 pulse
    step(1, 1, 0, 0, 0, 0, 0, "R1");
    check("R1", "record", int'(rd_data), 8'hC0);
    idle("R9");
    step(0, 0, 0, 0, 0, 1, 0, "R3");
    // R2: order, R1 varied flags
    step(1, 0, 0, 0, 1, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 1, 0, 0, "R2");
    check("R1", "record", int'(rd_data), 8'h88);
    step(0, 0, 0, 0, 0, 1, 0, "R3");
    check("R2", "second", int'(rd_data), 8'h80);
    step(0, 0, 0, 0, 0, 1, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 0, "R4");
    // R5: fill and overflow twice
    for (int i = 0; i < DEPTH; i++) step(1, i[0], 0, 0, i[1], 0, 0, "R5");
    step(1, 1, 0, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, 0, 0, "R5");
    check("R5", "head kept", int'(rd_data), 8'h80);
    // R6: full, push and pop together
    step(1, 0, 0, 0, 1, 1, 0, "R6");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 0, 1, 0, "R6");
    // R7: jabber record then sticky
    step(1, 0, 1, 0, 0, 0, 0, "R7");
    check("R7", "jabber record", int'(rd_data), 8'hA0);
    repeat (3) idle("R7");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    check("R7", "sticky", int'(needs_reset), 1);
    // R8: tx_rst with push in same cycle
    step(1, 0, 0, 0, 0, 0, 0, "R8");
    step(1, 1, 0, 1, 0, 1, 1, "R8");
    check("R8", "cleared", int'(needs_reset), 0);
    // R7 via dropped underrun on full queue
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 1, 0, 0, 0, "R7");
    check("R7", "dropped fatal", int'(needs_reset), 1);
    step(0, 0, 0, 0, 0, 0, 1, "R8");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      automatic int r = $urandom;
      step(r[0] | r[1], r[2] & r[3], (r[4:9] == 0), (r[10:15] == 0), r[16],
           r[17] & r[18], (r[19:24] == 0), "R2");
    end
    done = 1'b1;
    finish_run();
  end
endmodule